// File: doc/BRIEF.md
# Timer Master Trigger Selector

This block is the master side of timer-to-timer synchronization. It contains a small up-counter with an auto-reload limit, four compare channels and a software update strobe. From the events and levels these produce, it picks one and drives it onto a single trigger line, which a slave timer elsewhere on the chip consumes. A 3-bit mode field in a control register selects the source. The source can be the software update strobe, the counter enable, the update event, a channel-1 match pulse, or one of four compare reference levels.

A second field in the same register picks what feeds the first timer input. It is either the dedicated input pin or the exclusive-OR of three hall-sensor inputs. The register is written through a plain synchronous write-enable with a 32-bit data word, and its value is always visible on a read-back port.

Top module: `tmt_master_trig`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ctrl_q` reads 0, `trgo` is 0 and the counter holds 0.
- R2: A write with `wr_en` high stores `wr_data[6:4]` as the mode and `wr_data[7]` as the input select at the clock edge. `ctrl_q` returns those bits in the same positions, with every other bit 0.
- R3: With bit 7 at 0, `ti1m` equals `ti1_in`. With bit 7 at 1, `ti1m` equals `hall_in[0]^hall_in[1]^hall_in[2]`. This path is combinational.
- R4: While `cen` is high, the counter steps by one per clock. After the value `reload` it wraps to 0, and that wrap cycle is an update event. While `cen` is low, the counter holds.
- R5: A cycle with `ug` high clears the counter at the edge and is an update event, whatever `cen` is.
- R6: Mode 3'b000: `trgo` equals `ug` of the previous cycle.
- R7: Mode 3'b001: `trgo` equals `cen` of the previous cycle.
- R8: Mode 3'b010: `trgo` is high for one cycle after each update event (wrap or `ug`).
- R9: Mode 3'b011: `trgo` pulses one cycle after every cycle in which `cen` is high and the counter equals `cmp_val[0]`. It pulses again on every later match.
- R10: Modes 3'b100 to 3'b111: `trgo` follows, one cycle late, the reference level of channel 1 to 4 (`cmp_val[0]` to `cmp_val[3]`). Each level is high while the counter is below that compare value.
- R11: `trgo` is registered. In the cycle of a mode write it still reflects the old mode's source. From the next cycle on, it reflects the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write enable |
| wr_data | input | 32 | Control register write data |
| ctrl_q | output | 32 | Control register read-back |
| cen | input | 1 | Counter enable |
| ug | input | 1 | Software update strobe |
| reload | input | CNT_W | Auto-reload limit |
| cmp_val | input | 4*CNT_W | Compare values, channel 1 in the low slice |
| hall_in | input | 3 | Hall-sensor inputs |
| ti1_in | input | 1 | First timer input pin |
| ti1m | output | 1 | Selected first timer input |
| trgo | output | 1 | Trigger output to a slave timer |

## Verification
The assertions take for granted that every input is already synchronous to `clk`. The hall and pin inputs in particular are treated as sampled values, not raw pins. They also assume that `reload` and the compare values stay put while the counter runs, so that a wrap and a channel-1 match are ordinary single events. The stimulus fixes `reload` and all four compare values before reset is released. Channel 4's value is set above `reload`, so that level stays high. Every input change is driven on the falling edge, with `ug` pulses and `cen` gaps placed part-way through each mode's run.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef enum logic [2:0] {
    MM_SWUPD  = 3'd0,
    MM_ENABLE = 3'd1,
    MM_UPDATE = 3'd2,
    MM_CPULSE = 3'd3,
    MM_REF1   = 3'd4,
    MM_REF2   = 3'd5,
    MM_REF3   = 3'd6,
    MM_REF4   = 3'd7
  } mm_sel_e;

  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam int INSEL_BIT = 7;

  function automatic logic hall_combine(input logic [2:0] h);
    return h[0] ^ h[1] ^ h[2];
  endfunction
endpackage

// File: rtl/tmt_ctrl_reg.sv
module tmt_ctrl_reg
  import tmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic        insel_q,
  output logic [31:0] rd_q
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[31:INSEL_BIT+1], wr_data[MODE_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      insel_q <= 1'b0;
    end else if (wr_en) begin
      mode_q  <= wr_data[MODE_LSB +: MODE_W];
      insel_q <= wr_data[INSEL_BIT];
    end
  end

  always_comb begin
    rd_q = '0;
    rd_q[MODE_LSB +: MODE_W] = mode_q;
    rd_q[INSEL_BIT] = insel_q;
  end
endmodule

// File: rtl/tmt_counter.sv
module tmt_counter #(
  parameter int CNT_W = 8,
  parameter int NCH   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cen,
  input  logic                      ug,
  input  logic [CNT_W-1:0]          reload,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0]          cnt,
  output logic                      uev,
  output logic                      cc1_evt,
  output logic [NCH-1:0]            ocref
);
  logic wrap;

  assign wrap    = cen && (cnt == reload);
  assign uev     = ug || wrap;
  assign cc1_evt = cen && (cnt == cmp_val[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ug)     cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (cen)    cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ref
    assign ocref[k] = (cnt < cmp_val[k]);
  end
endmodule

// File: rtl/tmt_trig_sel.sv
module tmt_trig_sel
  import tmt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              ug,
  input  logic              cen,
  input  logic              uev,
  input  logic              cc1_evt,
  input  logic [NCH-1:0]    ocref,
  output logic              trgo
);
  localparam int REF_SEL_W = $clog2(NCH);
  logic src;
  logic [REF_SEL_W-1:0] ref_idx;

  assign ref_idx = mode[REF_SEL_W-1:0];

  always_comb begin
    case (mm_sel_e'(mode))
      MM_SWUPD:  src = ug;
      MM_ENABLE: src = cen;
      MM_UPDATE: src = uev;
      MM_CPULSE: src = cc1_evt;
      default:   src = ocref[ref_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trgo <= 1'b0;
    else        trgo <= src;
  end
endmodule

// File: rtl/tmt_master_trig.sv
module tmt_master_trig
  import tmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           ctrl_q,
  input  logic                  cen,
  input  logic                  ug,
  input  logic [CNT_W-1:0]      reload,
  input  logic [3:0][CNT_W-1:0] cmp_val,
  input  logic [2:0]            hall_in,
  input  logic                  ti1_in,
  output logic                  ti1m,
  output logic                  trgo
);
  localparam int NCH = 4;

  logic [MODE_W-1:0] mode_q;
  logic              insel_q;
  logic [CNT_W-1:0]  cnt;
  logic              uev;
  logic              cc1_evt;
  logic [NCH-1:0]    ocref;

  tmt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_q(mode_q), .insel_q(insel_q), .rd_q(ctrl_q)
  );

  tmt_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cen(cen), .ug(ug), .reload(reload),
    .cmp_val(cmp_val), .cnt(cnt), .uev(uev), .cc1_evt(cc1_evt), .ocref(ocref)
  );

  tmt_trig_sel #(.NCH(NCH)) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .ug(ug), .cen(cen), .uev(uev),
    .cc1_evt(cc1_evt), .ocref(ocref), .trgo(trgo)
  );

  assign ti1m = insel_q ? hall_combine(hall_in) : ti1_in;
endmodule

// File: rtl/tmt_master_trig_chk.sv
module tmt_master_trig_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_q,
  input logic [2:0]       mode_q,
  input logic             cen,
  input logic             ug,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic             uev,
  input logic             cc1_evt,
  input logic [3:0]       ocref,
  input logic [2:0]       hall_in,
  input logic             ti1_in,
  input logic             ti1m,
  input logic             trgo
);
  assert_ctrl_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31:8] == '0) && (ctrl_q[3:0] == '0));

  assert_ti1_hall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |-> (ti1m == (hall_in[0] ^ hall_in[1] ^ hall_in[2])));

  assert_ti1_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[7] |-> (ti1m == ti1_in));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && cnt == reload) |=> (cnt == '0));

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !ug) |=> $stable(cnt));

  assert_ug_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0));

  assert_ug_is_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ug |-> uev);

  assert_trgo_ug_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_q) == 3'd0) |-> (trgo == $past(ug)));

  assert_trgo_cen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_q) == 3'd1) |-> (trgo == $past(cen)));

  assert_trgo_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_q) == 3'd2) |-> (trgo == $past(uev)));

  assert_trgo_cpulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_q) == 3'd3) |-> (trgo == $past(cc1_evt)));

  for (genvar k = 0; k < 4; k++) begin : g_ref_chk
    assert_trgo_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_q) == 3'(4 + k)) |-> (trgo == $past(ocref[k])));
  end
endmodule

bind tmt_master_trig tmt_master_trig_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .mode_q(mode_q), .cen(cen), .ug(ug),
  .reload(reload), .cnt(cnt), .uev(uev), .cc1_evt(cc1_evt), .ocref(ocref),
  .hall_in(hall_in), .ti1_in(ti1_in), .ti1m(ti1m), .trgo(trgo)
);

// File: tb/tmt_master_trig_tb.sv
`timescale 1ns/1ps
module tmt_master_trig_tb;
  localparam int CNT_W = 8;
  localparam int ARR = 9;
  localparam int C1 = 3, C2 = 5, C3 = 7, C4 = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cen = 0, ug = 0, ti1_in = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_q;
  logic [CNT_W-1:0] reload;
  logic [3:0][CNT_W-1:0] cmp_val;
  logic [2:0] hall_in = '0;
  logic ti1m, trgo;

  always #2.5 clk = ~clk;

  tmt_master_trig #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .cen(cen), .ug(ug), .reload(reload), .cmp_val(cmp_val), .hall_in(hall_in),
    .ti1_in(ti1_in), .ti1m(ti1m), .trgo(trgo)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, failures = 0;
  int m_cnt = 0;
  int m_mode = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R6";
      1: return "R7";
      2: return "R8 R4 R5";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic expect_src(input int m, input bit c, input bit u);
    bit wrap, upd, hit;
    wrap = c && (m_cnt == ARR);
    upd  = u || wrap;
    hit  = c && (m_cnt == C1);
    case (m)
      0: return u;
      1: return c;
      2: return upd;
      3: return hit;
      4: return m_cnt < C1;
      5: return m_cnt < C2;
      6: return m_cnt < C3;
      default: return m_cnt < C4;
    endcase
  endfunction

  // driver: one clock of stimulus, expected trgo pushed for the next edge
  task automatic step(input bit c, input bit u, input bit we, input logic [31:0] wd, input string extra);
    item_t it;
    @(negedge clk);
    cen = c; ug = u; wr_en = we; wr_data = wd;
    it.exp = expect_src(m_mode, c, u);
    it.tag = {mode_tag(m_mode), extra};
    sb.push_back(it);
    @(posedge clk);
    if (u) m_cnt = 0;
    else if (c) m_cnt = (m_cnt == ARR) ? 0 : m_cnt + 1;
    if (we) m_mode = int'(wd[6:4]);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(trgo === it.exp, it.tag, {31'b0, trgo}, {31'b0, it.exp});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    reload  = CNT_W'(ARR);
    cmp_val = {CNT_W'(C4), CNT_W'(C3), CNT_W'(C2), CNT_W'(C1)};
    ti1_in  = 1'b1;
    repeat (3) @(negedge clk);
    check(trgo === 1'b0, "R1 trgo in reset", {31'b0, trgo}, 0);
    check(ctrl_q === 32'h0, "R1 ctrl in reset", ctrl_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trgo === 1'b0, "R1 trgo after reset", {31'b0, trgo}, 0);
    check(ctrl_q === 32'h0, "R1 ctrl after reset", ctrl_q, 0);
    check(ti1m === ti1_in, "R3 pin default", {31'b0, ti1m}, {31'b0, ti1_in});

    // R2: all-ones write keeps only bits 7:4
    step(0, 0, 1, 32'hFFFF_FFFF, " R2");
    @(negedge clk);
    wr_en = 0;
    check(ctrl_q === 32'h0000_00F0, "R2 readback", ctrl_q, 32'hF0);

    // R3: hall exclusive-OR with select bit set
    for (int h = 0; h < 8; h++) begin
      @(negedge clk);
      hall_in = 3'(h); ti1_in = h[0];
      #1;
      check(ti1m === (hall_in[0] ^ hall_in[1] ^ hall_in[2]), "R3 hall xor", {31'b0, ti1m},
            {31'b0, hall_in[0] ^ hall_in[1] ^ hall_in[2]});
    end
    step(0, 0, 1, 32'h0000_0000, " R2");
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      wr_en = 0;
      hall_in = 3'(h + 3); ti1_in = h[1];
      #1;
      check(ti1m === ti1_in, "R3 pin path", {31'b0, ti1m}, {31'b0, ti1_in});
    end
    check(ctrl_q === 32'h0, "R2 cleared", ctrl_q, 0);

    // every mode: write (R11 at the switch), then run with ug and a cen gap
    for (int m = 0; m < 8; m++) begin
      step(1, 0, 1, 32'(m << 4), " R11");
      step(1, 0, 0, 32'h0, " R11");
      for (int i = 0; i < 32; i++) begin
        step((i < 20 || i > 23), (i == 13), 0, 32'h0, "");
      end
    end
    step(0, 0, 0, 32'h0, "");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule